// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous 32K x 8 static RAM. It accepts one single-byte read or write at a time through a request/ready handshake. It then plays out the memory's active-low chip-select, output-enable and write-strobe waveforms, each phase lasting a parameterised number of clock cycles. Read data is captured inside the controller and returned to the host with a one-cycle valid strobe.

A write starts with a data-setup phase. In this phase the chip is selected, the output enable is held inactive and the controller already drives the data lines. The write-strobe pulse follows, and it ends the write. The controller owns the data lines only during these two write phases. When a write follows a read, a run of idle cycles with every strobe inactive is inserted first, so that the memory's output drivers have released the bus before the controller drives it. All memory-side outputs come straight from flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0, ready is 1 and rd_valid is 0.
- R2: A request is accepted on a rising clock edge where req and ready are both 1. Ready is 0 from the following cycle until the operation, including any turnaround, has finished. It is 1 again in the first cycle after the last memory phase.
- R3: A write (req_we=1) holds sram_ce_n at 0 for T_DS_HOLD+T_WP consecutive cycles with sram_oe_n at 1 throughout. sram_we_n is 0 only for the last T_WP of those cycles.
- R4: sram_dq_oe is 1 only while sram_ce_n is 0 and sram_oe_n is 1. It is 1 for every cycle of a write, so write data is on the bus T_DS_HOLD cycles before the strobe falls.
- R5: A read (req_we=0) holds sram_ce_n and sram_oe_n at 0 for T_RD consecutive cycles, with sram_we_n at 1 and sram_dq_oe at 0.
- R6: The value on sram_dq_in in the final read cycle is presented on rd_data, with rd_valid at 1 for exactly one cycle: the cycle after the last read cycle. rd_valid stays 0 after writes.
- R7: A write accepted when the previous operation was a read waits T_TURN cycles after acceptance, with all strobes at 1 and sram_dq_oe at 0, before sram_ce_n falls.
- R8: A read, or a write whose previous operation was a write (or which is the first after reset), selects the chip in the cycle right after acceptance.
- R9: sram_we_n and sram_oe_n are never 0 at the same time.
- R10: sram_addr holds the accepted address while sram_ce_n is 0, regardless of later changes on req_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| ready | output | 1 | Controller idle, request may be accepted |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Captured read byte |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the controller's data driver |
| sram_dq_in | input | 8 | Data read back from the memory pins |

## Verification
The assertions take for granted only that the reset is applied before the first checked edge. They assume that the host does not depend on the memory side between operations. They do not assume that req stays quiet while ready is low. The stimulus raises req only in a cycle where ready is seen high and drops it right after acceptance. It then changes req_addr and req_wdata during the operation, which exercises the capture. The memory model drives sram_dq_in only while chip select and output enable are low and the write strobe is high. In all other cycles it returns a fixed filler byte, so a mistimed capture shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_READ
    } seq_st_e;

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_WP      = 1,
    parameter int T_DS_HOLD = 1,
    parameter int T_RD      = 2,
    parameter int T_TURN    = 1,
    parameter int CNT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_done
);

    localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(T_WP - 1);
    localparam logic [CNT_W-1:0] LD_DS   = CNT_W'(T_DS_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(T_RD - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(T_TURN - 1);

    typedef struct packed {
        seq_st_e             st;
        logic                last_rd;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic                dq_oe;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    if (!req_we) begin
                        s_d.st  = ST_READ;
                        tmr_val = LD_RD;
                    end else if (s_q.last_rd) begin
                        s_d.st  = ST_TURN;
                        tmr_val = LD_TURN;
                    end else begin
                        s_d.st  = ST_WSET;
                        tmr_val = LD_DS;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    s_d.st      = ST_WSET;
                    s_d.last_rd = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_DS;
                end
            end
            ST_WSET: begin
                if (tmr_done) begin
                    s_d.st   = ST_WPUL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WP;
                end
            end
            ST_WPUL: begin
                if (tmr_done) begin
                    s_d.st      = ST_IDLE;
                    s_d.last_rd = 1'b0;
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    s_d.st      = ST_IDLE;
                    s_d.rdata   = sram_dq_in;
                    s_d.rvalid  = 1'b1;
                    s_d.last_rd = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        // Strobes registered from the next state: no decode glitches at the pins.
        s_d.ce_n  = !(s_d.st inside {ST_WSET, ST_WPUL, ST_READ});
        s_d.oe_n  = (s_d.st != ST_READ);
        s_d.we_n  = (s_d.st != ST_WPUL);
        s_d.dq_oe = (s_d.st inside {ST_WSET, ST_WPUL});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.ce_n    <= 1'b1;
            s_q.oe_n    <= 1'b1;
            s_q.we_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready       = (s_q.st == ST_IDLE);
    assign rd_valid    = s_q.rvalid;
    assign rd_data     = s_q.rdata;
    assign sram_ce_n   = s_q.ce_n;
    assign sram_oe_n   = s_q.oe_n;
    assign sram_we_n   = s_q.we_n;
    assign sram_addr   = s_q.addr;
    assign sram_dq_out = s_q.wdata;
    assign sram_dq_oe  = s_q.dq_oe;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_WP      = 1,
    parameter int T_DS_HOLD = 1,
    parameter int T_RD      = 2,
    parameter int T_TURN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int T_MAX_A = (T_WP > T_DS_HOLD) ? T_WP : T_DS_HOLD;
    localparam int T_MAX_B = (T_RD > T_TURN) ? T_RD : T_TURN;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    sram_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .T_WP      (T_WP),
        .T_DS_HOLD (T_DS_HOLD),
        .T_RD      (T_RD),
        .T_TURN    (T_TURN),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ready       (ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .sram_ce_n   (sram_ce_n),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_done    (tmr_done)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe
);

    // R9: never strobe a write while the memory is asked to drive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // R4: own driver only with chip selected and memory outputs disabled
    p_drive_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_ce_n && sram_oe_n));

    // R3: write pulse only inside a chip-select window
    p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    // R5: a read window never has the driver on or the write strobe low
    p_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_dq_oe && !sram_ce_n));

    // R2: no new acceptance possible while the memory is in use
    p_busy_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !ready);

    // R6: read strobe lasts one cycle
    p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10: address frozen across a chip-select window
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .rd_valid   (rd_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    localparam int P_WP = 1, P_DS = 1, P_RD = 2, P_TURN = 1;
    localparam logic [7:0] FILL = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [14:0] m_addr;
    logic [7:0]  dq_out, dq_in;
    logic [7:0]  mem [0:255];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sram_async_ctrl #(.T_WP(P_WP), .T_DS_HOLD(P_DS), .T_RD(P_RD), .T_TURN(P_TURN))
    i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(ce_n),
        .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(m_addr),
        .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
    );

    // Memory model: drives only in a read window, stores during the write strobe.
    assign dq_in = (!ce_n && !oe_n && we_n) ? mem[m_addr[7:0]] : FILL;

    always @(negedge clk)
        if (!ce_n && !we_n && dq_oe) mem[m_addr[7:0]] <= dq_out;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one operation and measure the memory-side waveform at negedges.
    task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          output int turn, output int nce, output int nwe,
                          output int noe, output int ndrv, output int weofs,
                          output int nbusy, output int badaddr, output int conflict,
                          output bit rv, output logic [7:0] rd, output bit rv_after);
        int idx = 0, first_ce = -1, first_we = -1;
        turn = 0; nce = 0; nwe = 0; noe = 0; ndrv = 0; nbusy = 0;
        badaddr = 0; conflict = 0;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_addr = ~a; req_wdata = ~d;
        while (!ready && idx < 100) begin
            nbusy++;
            if (!we_n && !oe_n) conflict++;
            if (dq_oe && (ce_n || !oe_n)) conflict++;
            if (!ce_n) begin
                if (first_ce < 0) first_ce = idx;
                nce++;
                if (m_addr != a) badaddr++;
            end else if (first_ce < 0) begin
                turn++;
                if (dq_oe || !oe_n || !we_n) conflict++;
            end
            if (!we_n) begin
                if (first_we < 0) first_we = idx;
                nwe++;
            end
            if (!oe_n) noe++;
            if (dq_oe) ndrv++;
            idx++;
            @(negedge clk);
        end
        weofs = (first_we < 0) ? -1 : first_we - first_ce;
        rv = rd_valid; rd = rd_data;
        @(negedge clk);
        rv_after = rd_valid;
    endtask

    task automatic t_reset();
        chk("R1 ce_n", int'(ce_n), 1);
        chk("R1 oe_n", int'(oe_n), 1);
        chk("R1 we_n", int'(we_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 rd_valid", int'(rd_valid), 0);
    endtask

    task automatic t_write(input logic [14:0] a, input logic [7:0] d, input int exp_turn);
        int turn, nce, nwe, noe, ndrv, weofs, nbusy, badaddr, conflict;
        bit rv, rva; logic [7:0] rd;
        run_op(1'b1, a, d, turn, nce, nwe, noe, ndrv, weofs, nbusy, badaddr, conflict, rv, rd, rva);
        if (exp_turn != 0) chk("R7 turnaround cycles", turn, exp_turn);
        else               chk("R8 no turnaround", turn, 0);
        chk("R3 ce low cycles", nce, P_DS + P_WP);
        chk("R3 we low cycles", nwe, P_WP);
        chk("R3 we offset", weofs, P_DS);
        chk("R3 oe stays high", noe, 0);
        chk("R4 drive cycles", ndrv, P_DS + P_WP);
        chk("R2 busy length", nbusy, exp_turn + P_DS + P_WP);
        chk("R10 address held", badaddr, 0);
        chk("R9 strobe conflicts", conflict, 0);
        chk("R6 no rd_valid on write", int'(rv) + int'(rva), 0);
        chk("R3 stored byte", int'(mem[a[7:0]]), int'(d));
    endtask

    task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
        int turn, nce, nwe, noe, ndrv, weofs, nbusy, badaddr, conflict;
        bit rv, rva; logic [7:0] rd;
        run_op(1'b0, a, 8'h00, turn, nce, nwe, noe, ndrv, weofs, nbusy, badaddr, conflict, rv, rd, rva);
        chk("R8 read starts at once", turn, 0);
        chk("R5 ce low cycles", nce, P_RD);
        chk("R5 oe low cycles", noe, P_RD);
        chk("R5 we stays high", nwe, 0);
        chk("R5 no drive", ndrv, 0);
        chk("R2 busy length", nbusy, P_RD);
        chk("R10 address held", badaddr, 0);
        chk("R9 strobe conflicts", conflict, 0);
        chk("R6 rd_valid", int'(rv), 1);
        chk("R6 rd_data", int'(rd), int'(exp));
        chk("R6 rd_valid one cycle", int'(rva), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(15'h0000, 8'hA5, 0);
        t_write(15'h7FFF, 8'h5A, 0);
        t_read (15'h0000, 8'hA5);
        t_write(15'h1234, 8'hFF, P_TURN);
        t_read (15'h7FFF, 8'h5A);
        t_read (15'h1234, 8'hFF);
        t_write(15'h0000, 8'h3C, P_TURN);
        t_write(15'h0001, 8'h00, 0);
        t_read (15'h0000, 8'h3C);
        t_read (15'h0001, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule